// File: doc/BRIEF.md
# Page Write Buffer and Cycle Timer

This block sits behind the serial command decoder of a byte-addressed nonvolatile memory. When a write-array command begins, the decoder hands over the start address. Each data byte that arrives is then placed in a page buffer at the current in-page offset. With each byte comes a permit bit that says whether its address lies outside the protected region. Only the low offset bits advance as bytes arrive. A transaction longer than a page therefore wraps inside the page, and later bytes replace earlier ones.

When chip select rises, the decoder reports whether the bit count stood on a byte boundary. If it did, and at least one byte was loaded, the block starts a timed internal write cycle. During that cycle it raises busy, presents every permitted buffered byte to the array as a one-cycle write strobe, and counts the cycle length down. At the end it lowers busy and pulses a done signal, which the surrounding logic uses to clear its write-enable latch. Array locations that were not loaded, or whose permit was low, are never strobed.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, busy, cycle_done and arr_we are all 0.
- R2: A start pulse taken while idle sets load_addr to start_addr. Each accepted byte then advances load_addr[5:0] by one modulo 64, and load_addr[ADDR_W-1:6] stays fixed.
- R3: If more than 64 bytes are loaded, the offset wraps. The byte loaded last at an offset is the one written to the array.
- R4: A cs_rise with bit_aligned high, after at least one byte was loaded, raises busy on the next cycle. Busy then stays high for exactly TWC_CYCLES cycles (default 100, never less than 64).
- R5: A cs_rise with bit_aligned low, or one that comes before any byte was loaded, aborts the transaction. Busy stays 0 and no array write occurs.
- R6: A byte loaded with wr_permit low is never written to the array. Array writes (arr_we) occur only while busy is high.
- R7: Array locations in the page that were not loaded during the transaction keep their previous contents.
- R8: cycle_done is a one-cycle pulse in the first cycle in which busy is low again after a write cycle.
- R9: While busy is high, start_valid and byte_valid are ignored. load_addr and the array contents that will be written do not change.
- R10: During the cycle, each loaded and permitted offset is written exactly once, at address {upper start bits, offset}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Pulse: a write-array transaction begins at start_addr |
| start_addr | input | ADDR_W | Start address of the transaction |
| byte_valid | input | 1 | Pulse: byte_data holds a complete received byte |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| bit_aligned | input | 1 | With cs_rise: the bit count was a multiple of 8 |
| wr_permit | input | 1 | With byte_valid: load_addr is not write protected |
| load_addr | output | ADDR_W | Address the next loaded byte will go to |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |
| cycle_done | output | 1 | One-cycle pulse at the end of a write cycle |

## Verification
load_addr moves one cycle after each accepted byte, so the bench compares it at the falling edge before it drives the next byte. Busy is due one cycle after the cs_rise cycle. It is read at the next falling edge, and then counted at falling edges until it drops, where the count must equal TWC_CYCLES and cycle_done must be high. cycle_done must be low again one falling edge later. Array writes are captured at rising edges. The bench compares a page image only after cycle_done, and it checks aborts after several quiet cycles, so no result is sampled before it is due.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Next in-page offset: only the low bits move, the page is a power of two
  function automatic int unsigned pg_next_ofs(input int unsigned ofs,
                                              input int unsigned page);
    return (ofs + 1) % page;
  endfunction

  // Effective cycle length: the commit scan needs one cycle per page slot
  function automatic int unsigned pg_cycle_len(input int unsigned twc,
                                               input int unsigned page);
    return (twc < page) ? page : twc;
  endfunction

endpackage

// File: rtl/pgwr_loader.sv
module pgwr_loader #(
  parameter int PAGE = 64,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [IW-1:0] clear_ofs,
  input  logic          load_en,
  input  logic [7:0]    wr_data,
  input  logic          permit,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_ok,
  output logic [IW-1:0] ofs,
  output logic          got_byte
);
  import pgwr_pkg::*;

  logic [7:0]      page_q [PAGE];
  logic [PAGE-1:0] ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q     <= '0;
      ofs      <= '0;
      got_byte <= 1'b0;
    end else if (clear) begin
      ok_q     <= '0;
      ofs      <= clear_ofs;
      got_byte <= 1'b0;
    end else if (load_en) begin
      ok_q[ofs] <= permit;
      ofs       <= IW'(pg_next_ofs(ofs, PAGE));
      got_byte  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en && !clear) page_q[ofs] <= wr_data;
  end

  assign rd_data = page_q[rd_idx];
  assign rd_ok   = ok_q[rd_idx];

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int TWC  = 100,
  parameter int PAGE = 64,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] scan_idx,
  output logic          scan_live,
  output logic          done
);
  localparam int CW = $clog2(TWC + 1);

  logic [CW-1:0] cnt_q;
  logic [IW:0]   scan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        cnt_q  <= CW'(TWC);
        scan_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
        if (scan_q < (IW+1)'(PAGE)) scan_q <= scan_q + 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign scan_idx  = scan_q[IW-1:0];
  assign scan_live = busy && (scan_q < (IW+1)'(PAGE));

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int TWC_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              bit_aligned,
  input  logic              wr_permit,
  output logic [ADDR_W-1:0] load_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              cycle_done
);
  import pgwr_pkg::*;

  localparam int IW      = $clog2(PAGE_BYTES);
  localparam int HW      = ADDR_W - IW;
  localparam int TWC_EFF = pg_cycle_len(TWC_CYCLES, PAGE_BYTES);

  logic          loading_q;
  logic [HW-1:0] base_hi_q;
  logic          start_take, load_take, prog_go;
  logic [IW-1:0] ofs, scan_idx;
  logic          got_byte, scan_live, rd_ok;
  logic [7:0]    rd_data;

  assign start_take = start_valid && !busy;
  assign load_take  = byte_valid && loading_q && !busy;
  assign prog_go    = cs_rise && loading_q && !busy && bit_aligned && got_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_q <= 1'b0;
      base_hi_q <= '0;
    end else if (start_take) begin
      loading_q <= 1'b1;
      base_hi_q <= start_addr[ADDR_W-1:IW];
    end else if (cs_rise) begin
      loading_q <= 1'b0;
    end
  end

  pgwr_loader #(.PAGE(PAGE_BYTES), .IW(IW)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .clear(start_take), .clear_ofs(start_addr[IW-1:0]),
    .load_en(load_take), .wr_data(byte_data), .permit(wr_permit),
    .rd_idx(scan_idx), .rd_data(rd_data), .rd_ok(rd_ok),
    .ofs(ofs), .got_byte(got_byte)
  );

  pgwr_timer #(.TWC(TWC_EFF), .PAGE(PAGE_BYTES), .IW(IW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_go),
    .busy(busy), .scan_idx(scan_idx), .scan_live(scan_live), .done(cycle_done)
  );

  assign load_addr = {base_hi_q, ofs};
  assign arr_we    = scan_live && rd_ok;
  assign arr_addr  = {base_hi_q, scan_idx};
  assign arr_wdata = rd_data;

  AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R6
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (!busy && $past(busy))); // R8
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && bit_aligned)); // R4
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !bit_aligned && !busy) |=> !busy); // R5
  AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && loading_q && !busy && !start_valid) |=>
      ((load_addr[IW-1:0] == $past(load_addr[IW-1:0]) + 1'b1) &&
       $stable(load_addr[ADDR_W-1:IW]))); // R2
  AST_FROZEN_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(load_addr)); // R9

endmodule

// File: tb/test_pgwr_engine.sv
module test_pgwr_engine;
  localparam int AW  = 15;
  localparam int PG  = 64;
  localparam int TWC = 100;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          cs_rise = 1'b0;
  logic          bit_aligned = 1'b0;
  logic          wr_permit = 1'b0;
  logic [AW-1:0] load_addr;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;
  logic          busy;
  logic          cycle_done;

  int total = 0;
  int bad   = 0;
  int wr_total = 0;
  logic [7:0] arr     [MEM];
  logic [7:0] exp_mem [MEM];

  always #10 clk = ~clk;

  pgwr_engine #(.ADDR_W(AW), .PAGE_BYTES(PG), .TWC_CYCLES(TWC)) i_pgwr_engine (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
    .bit_aligned(bit_aligned), .wr_permit(wr_permit), .load_addr(load_addr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .busy(busy), .cycle_done(cycle_done)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      arr[arr_addr] = arr_wdata;
      wr_total++;
    end
  end

  function automatic bit is_prot(input int lvl, input logic [AW-1:0] a);
    case (lvl)
      1: return a[AW-1:AW-2] == 2'b11;
      2: return a[AW-1];
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] addr, input int n, input bit aligned,
                         input int lvl, input bit junk);
    logic [7:0] pdat [PG];
    bit pok [PG];
    bit pld [PG];
    int o, w0, cyc, nexp, miss_ld, miss_other;
    bit go, perm;
    logic [AW-1:0] a;
    for (int k = 0; k < PG; k++) begin pok[k] = 0; pld[k] = 0; pdat[k] = '0; end
    @(negedge clk);
    start_valid = 1'b1; start_addr = addr;
    @(negedge clk);
    start_valid = 1'b0;
    o = int'(addr[5:0]);
    for (int i = 0; i < n; i++) begin
      a = {addr[AW-1:6], 6'(o)};
      check(load_addr == a, "R2 load_addr", int'(load_addr), int'(a));
      perm = !is_prot(lvl, a);
      byte_data = 8'($urandom);
      wr_permit = perm;
      byte_valid = 1'b1;
      pdat[o] = byte_data; pok[o] = perm; pld[o] = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      o = (o + 1) % PG;
    end
    w0 = wr_total;
    cs_rise = 1'b1; bit_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0; bit_aligned = 1'b0;
    go = aligned && (n > 0);
    check(busy == go, go ? "R4 busy rise" : "R5 abort busy", int'(busy), int'(go));
    if (!go) begin
      repeat (5) @(negedge clk);
      check(wr_total == w0 && !busy, "R5 abort no write", wr_total - w0, 0);
      return;
    end
    cyc = 1;
    while (1) begin
      if (junk && cyc >= 3 && cyc < 10) begin
        start_valid = 1'b1; start_addr = AW'($urandom);
        byte_valid = 1'b1; byte_data = 8'($urandom); wr_permit = 1'b1;
      end else begin
        start_valid = 1'b0; byte_valid = 1'b0;
      end
      @(negedge clk);
      if (junk && cyc >= 3 && cyc < 10)
        check(load_addr == {addr[AW-1:6], 6'(o)}, "R9 load_addr frozen",
              int'(load_addr), int'({addr[AW-1:6], 6'(o)}));
      if (!busy) break;
      cyc++;
      if (cyc > TWC + 10) break;
    end
    start_valid = 1'b0; byte_valid = 1'b0;
    check(cyc == TWC, "R4 busy length", cyc, TWC);
    check(cycle_done == 1'b1, "R8 done pulse", int'(cycle_done), 1);
    @(negedge clk);
    check(cycle_done == 1'b0, "R8 done width", int'(cycle_done), 0);
    nexp = 0;
    for (int k = 0; k < PG; k++)
      if (pld[k] && pok[k]) begin
        exp_mem[{addr[AW-1:6], 6'(k)}] = pdat[k];
        nexp++;
      end
    check(wr_total - w0 == nexp, "R10 write count", wr_total - w0, nexp);
    miss_ld = 0; miss_other = 0;
    for (int k = 0; k < PG; k++) begin
      a = {addr[AW-1:6], 6'(k)};
      if (arr[a] !== exp_mem[a]) begin
        if (pld[k] && pok[k]) miss_ld++; else miss_other++;
      end
    end
    check(miss_ld == 0, "R3 loaded bytes", miss_ld, 0);
    check(miss_other == 0, "R6 R7 other locations", miss_other, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < MEM; k++) begin
      arr[k] = 8'(k) ^ 8'h3C;
      exp_mem[k] = 8'(k) ^ 8'h3C;
    end
    repeat (3) @(negedge clk);
    check(!busy && !cycle_done && !arr_we, "R1 reset state",
          int'({busy, cycle_done, arr_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cycle_done && !arr_we, "R1 after release",
          int'({busy, cycle_done, arr_we}), 0);
    run_txn(15'h0123, 1, 1'b1, 0, 1'b0);   // single byte
    run_txn(15'h0A3E, 70, 1'b1, 0, 1'b0);  // R3 wrap overwrite
    run_txn(15'h0400, 0, 1'b1, 0, 1'b0);   // R5 no byte
    run_txn(15'h0500, 5, 1'b0, 0, 1'b0);   // R5 unaligned
    run_txn(15'h7FF0, 20, 1'b1, 1, 1'b0);  // R6 protected page
    run_txn(15'h2C10, 12, 1'b1, 1, 1'b1);  // R9 junk during cycle
    for (int t = 0; t < 20; t++)
      run_txn(AW'($urandom), int'($urandom_range(0, 80)),
              ($urandom_range(0, 5) != 0), int'($urandom_range(0, 3)),
              bit'($urandom_range(0, 1)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule